// File: doc/BRIEF.md
# NAND Flash Page and Block Manager

This block models a small NAND-style flash array held in on-chip storage. The array is split into blocks, and each block into pages of a fixed number of words. A client issues one command at a time (page read, page program or block erase) with a block and page address. It then moves a full page of data through a streaming port that has a valid/ready handshake, one word per cycle. When the command finishes, the block raises a one-cycle completion pulse and reports a result code.

The block applies the access rules of NAND flash. Reads and programs always cover a whole page. Erase always covers a whole block and returns every word in it to all ones. Inside a block, pages must be programmed strictly in ascending order. Each block has a next-page pointer that advances on every successful program and goes back to zero only on erase. A program that targets any other page is refused before any data moves. A program to a block whose pages are all used is refused with a separate code. The default geometry is 4 blocks of 8 pages of 16 words, with 16-bit words.

Top module: `nandPageMgr`

## Requirements
- R1: After reset every word of every page reads as all ones and every block's next-page pointer is zero. cmdReady is 1, and done, rdValid and wrReady are 0.
- R2: A read (cmdOp=0) of an accepted page streams exactly WORDS_PER_PAGE words on rdData, word 0 first, one word per cycle in which rdValid and rdReady are both high. While rdReady is low, rdValid stays high and rdData does not change. done pulses with status 0 in the cycle after the last word is taken.
- R3: A program (cmdOp=1) to the page equal to its block's pointer raises wrReady and stores exactly WORDS_PER_PAGE words, one per cycle in which wrValid is high, in order. done then pulses with status 0 and the pointer advances by one.
- R4: A program to any page other than its block's pointer is refused. done pulses with status 1 in the cycle after acceptance, wrReady never rises, and the page contents do not change.
- R5: A program to a block whose pointer equals PAGES_PER_BLOCK is refused with status 2, whatever page is given, and no data is taken.
- R6: An erase (cmdOp=2) sets every word of the addressed block to all ones and resets its pointer to zero. done pulses with status 0 in the next cycle. Other blocks are not changed.
- R7: Command code 3 is refused. done pulses with status 3 in the next cycle and no array or pointer state changes.
- R8: cmdReady is high only when no transfer is in progress, and the read and write streams are never active at the same time.
- R9: Each block keeps its own pointer. Programming or erasing one block does not move the pointer of another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Idle and able to take a command |
| cmdOp | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| cmdBlock | input | BLK_W | Block address |
| cmdPage | input | PG_W | Page address within the block |
| wrData | input | DATA_W | Program data word |
| wrValid | input | 1 | Program data word present |
| wrReady | output | 1 | Program data is being taken |
| rdData | output | DATA_W | Read data word |
| rdValid | output | 1 | Read data word present |
| rdReady | input | 1 | Client takes the read word |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 ok, 1 order error, 2 block full, 3 invalid command; held until the next done |

## Verification
On every cycle the assertions check how the handshake behaves. They check that only one stream is active at a time, that no command is taken during a transfer, and that read data holds while the client stalls. They also check the cycle after each accepted command: an erase or invalid command finishes at once, a read starts streaming, and a program either opens the write stream or is refused with an order or full code. What lies in the array can only be shown by the bench's scenarios. These show that refused programs leave pages as they were, that erase restores all ones in one block only, that pointers stay separate per block, that a block refuses programs once full, and that a page reads back with the words in the right order.

// File: rtl/nandPkg.sv
package nandPkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } opE;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ORDER = 2'd1,
    ST_FULL  = 2'd2,
    ST_BADOP = 2'd3
  } statE;

  typedef struct packed {
    logic latch;  // capture block/page, clear word index
    logic beat;   // advance word index
    logic write;  // store wrData at current word
    logic erase;  // fill the commanded block with ones
    logic bump;   // advance the current block's next-page pointer
  } strobeT;
endpackage

// File: rtl/nandCtrl.sv
module nandCtrl
  import nandPkg::*;
#(
  parameter int PAGES = 8,
  parameter int PG_W  = 3,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [PG_W-1:0]  cmdPage,
  input  logic [PTR_W-1:0] ptrOfCmd,
  input  logic             lastBeat,
  input  logic             rdReady,
  input  logic             wrValid,
  output logic             cmdReady,
  output logic             rdValid,
  output logic             wrReady,
  output logic             done,
  output logic [1:0]       status,
  output strobeT           stb
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_PROG} stateE;

  stateE      state, stateN;
  logic       doneN;
  logic [1:0] statusQ, statusN;

  always_comb begin
    stb     = '0;
    stateN  = state;
    doneN   = 1'b0;
    statusN = statusQ;
    case (state)
      S_IDLE: if (cmdValid) begin
        case (opE'(cmdOp))
          OP_READ: begin
            stb.latch = 1'b1;
            stateN    = S_READ;
          end
          OP_PROG: begin
            if (ptrOfCmd == PTR_W'(PAGES)) begin
              doneN   = 1'b1;
              statusN = ST_FULL;
            end else if (PTR_W'(cmdPage) != ptrOfCmd) begin
              doneN   = 1'b1;
              statusN = ST_ORDER;
            end else begin
              stb.latch = 1'b1;
              stateN    = S_PROG;
            end
          end
          OP_ERASE: begin
            stb.erase = 1'b1;
            doneN     = 1'b1;
            statusN   = ST_OK;
          end
          default: begin
            doneN   = 1'b1;
            statusN = ST_BADOP;
          end
        endcase
      end
      S_READ: if (rdReady) begin
        stb.beat = 1'b1;
        if (lastBeat) begin
          doneN   = 1'b1;
          statusN = ST_OK;
          stateN  = S_IDLE;
        end
      end
      S_PROG: if (wrValid) begin
        stb.beat  = 1'b1;
        stb.write = 1'b1;
        if (lastBeat) begin
          stb.bump = 1'b1;
          doneN    = 1'b1;
          statusN  = ST_OK;
          stateN   = S_IDLE;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      statusQ <= ST_OK;
    end else begin
      state   <= stateN;
      done    <= doneN;
      statusQ <= statusN;
    end
  end

  assign cmdReady = (state == S_IDLE);
  assign rdValid  = (state == S_READ);
  assign wrReady  = (state == S_PROG);
  assign status   = statusQ;
endmodule

// File: rtl/nandData.sv
module nandData
  import nandPkg::*;
#(
  parameter int NB    = 4,
  parameter int NP    = 8,
  parameter int NW    = 16,
  parameter int DW    = 16,
  parameter int BLK_W = 2,
  parameter int PG_W  = 3,
  parameter int WD_W  = 4,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [BLK_W-1:0] cmdBlock,
  input  logic [PG_W-1:0]  cmdPage,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  output logic [PTR_W-1:0] ptrOfCmd,
  output logic             lastBeat
);
  localparam int TOTAL    = NB * NP * NW;
  localparam int ADDR_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int BLK_SPAN = NP * NW;

  logic [DW-1:0]    mem    [TOTAL];
  logic [PTR_W-1:0] nextPg [NB];
  logic [BLK_W-1:0] curBlk;
  logic [PG_W-1:0]  curPg;
  logic [WD_W-1:0]  wordIdx;
  logic [ADDR_W-1:0] wordAddr;
  int               eraseBase;

  assign wordAddr  = ADDR_W'((int'(curBlk) * NP + int'(curPg)) * NW + int'(wordIdx));
  assign eraseBase = int'(cmdBlock) * BLK_SPAN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '1;
      for (int b = 0; b < NB; b++) nextPg[b] <= '0;
      curBlk  <= '0;
      curPg   <= '0;
      wordIdx <= '0;
    end else begin
      if (stb.latch) begin
        curBlk  <= cmdBlock;
        curPg   <= cmdPage;
        wordIdx <= '0;
      end else if (stb.beat) begin
        wordIdx <= lastBeat ? '0 : wordIdx + 1'b1;
      end
      if (stb.write) mem[wordAddr] <= wrData;
      if (stb.erase) begin
        for (int k = 0; k < BLK_SPAN; k++) mem[ADDR_W'(eraseBase + k)] <= '1;
        nextPg[cmdBlock] <= '0;
      end
      if (stb.bump) nextPg[curBlk] <= nextPg[curBlk] + 1'b1;
    end
  end

  assign rdData   = mem[wordAddr];
  assign ptrOfCmd = nextPg[cmdBlock];
  assign lastBeat = (wordIdx == WD_W'(NW - 1));
endmodule

// File: rtl/nandPageMgr.sv
module nandPageMgr
  import nandPkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int WORDS_PER_PAGE  = 16,
  parameter int DATA_W          = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int PG_W  = (PAGES_PER_BLOCK > 1) ? $clog2(PAGES_PER_BLOCK) : 1,
  localparam int WD_W  = (WORDS_PER_PAGE > 1) ? $clog2(WORDS_PER_PAGE) : 1,
  localparam int PTR_W = $clog2(PAGES_PER_BLOCK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [BLK_W-1:0]  cmdBlock,
  input  logic [PG_W-1:0]   cmdPage,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              done,
  output logic [1:0]        status
);
  strobeT           stb;
  logic [PTR_W-1:0] ptrOfCmd;
  logic             lastBeat;

  nandCtrl #(.PAGES(PAGES_PER_BLOCK), .PG_W(PG_W), .PTR_W(PTR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPage(cmdPage),
    .ptrOfCmd(ptrOfCmd), .lastBeat(lastBeat), .rdReady(rdReady), .wrValid(wrValid),
    .cmdReady(cmdReady), .rdValid(rdValid), .wrReady(wrReady), .done(done),
    .status(status), .stb(stb)
  );

  nandData #(
    .NB(NUM_BLOCKS), .NP(PAGES_PER_BLOCK), .NW(WORDS_PER_PAGE), .DW(DATA_W),
    .BLK_W(BLK_W), .PG_W(PG_W), .WD_W(WD_W), .PTR_W(PTR_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdBlock(cmdBlock), .cmdPage(cmdPage),
    .wrData(wrData), .rdData(rdData), .ptrOfCmd(ptrOfCmd), .lastBeat(lastBeat)
  );
endmodule

// File: rtl/nandPageMgrChk.sv
module nandPageMgrChk #(
  parameter int BLK_W  = 2,
  parameter int PG_W   = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdOp,
  input logic [BLK_W-1:0]  cmdBlock,
  input logic [PG_W-1:0]   cmdPage,
  input logic [DATA_W-1:0] wrData,
  input logic              wrValid,
  input logic              wrReady,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              rdReady,
  input logic              done,
  input logic [1:0]        status
);
  logic accept;
  assign accept = cmdValid && cmdReady;

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrReady)); // R8
  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid || wrReady) |-> !cmdReady); // R8
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData))); // R2
  AST_READ_START: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'd0) |=> (rdValid && !done)); // R2
  AST_ERASE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'd2) |=> (done && status == 2'd0 && cmdReady)); // R6
  AST_BADOP_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'd3) |=> (done && status == 2'd3 && cmdReady)); // R7
  AST_PROG_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (accept && cmdOp == 2'd1) |=>
      (wrReady || (done && (status == 2'd1 || status == 2'd2)))); // R5
endmodule

bind nandPageMgr nandPageMgrChk #(.BLK_W(BLK_W), .PG_W(PG_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_nandPageMgr.sv
module test_nandPageMgr;
  localparam int NB = 4, NP = 8, NW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = '0;
  logic [1:0]  cmdBlock = '0;
  logic [2:0]  cmdPage = '0;
  logic [15:0] wrData = '0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [15:0] rdData;
  logic        rdValid;
  logic        rdReady = 1'b1;
  logic        done;
  logic [1:0]  status;

  always #10 clk = ~clk;

  nandPageMgr i_nandPageMgr (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .cmdPage(cmdPage), .wrData(wrData), .wrValid(wrValid),
    .wrReady(wrReady), .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .done(done), .status(status)
  );

  int errors = 0;
  int checks = 0;
  logic [15:0] mdl [NB*NP*NW];

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] blk;
    logic [2:0] pg;
    logic [7:0] seed;
    logic [1:0] exp;
  } vecT;

  localparam vecT VEC [16] = '{
    '{2'd0, 2'd0, 3'd0, 8'h00, 2'd0},
    '{2'd1, 2'd0, 3'd0, 8'h11, 2'd0},
    '{2'd1, 2'd0, 3'd2, 8'hA0, 2'd1},
    '{2'd0, 2'd0, 3'd2, 8'h00, 2'd0},
    '{2'd1, 2'd0, 3'd1, 8'h22, 2'd0},
    '{2'd0, 2'd0, 3'd1, 8'h00, 2'd0},
    '{2'd1, 2'd1, 3'd0, 8'h33, 2'd0},
    '{2'd0, 2'd1, 3'd0, 8'h00, 2'd0},
    '{2'd2, 2'd0, 3'd0, 8'h00, 2'd0},
    '{2'd0, 2'd0, 3'd0, 8'h00, 2'd0},
    '{2'd0, 2'd1, 3'd0, 8'h00, 2'd0},
    '{2'd1, 2'd0, 3'd0, 8'h44, 2'd0},
    '{2'd3, 2'd0, 3'd0, 8'h00, 2'd3},
    '{2'd0, 2'd0, 3'd0, 8'h00, 2'd0},
    '{2'd1, 2'd0, 3'd0, 8'h55, 2'd1},
    '{2'd0, 2'd0, 3'd0, 8'h00, 2'd0}
  };

  function automatic logic [15:0] pat(input logic [7:0] seed, input int w);
    return {seed, 8'(w)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input int blk, input int pg,
                        input logic [7:0] seed, input bit throttle,
                        output logic [1:0] st, output int beats, output int bad,
                        output bit busyCmd);
    int  base;
    bit  tog;
    base = (blk * NP + pg) * NW;
    tog = 1'b0;
    beats = 0; bad = 0; busyCmd = 1'b0; st = '0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdBlock = 2'(blk); cmdPage = 3'(pg);
    @(negedge clk);
    cmdValid = 1'b0;
    forever begin
      if (done) begin
        st = status;
        break;
      end
      if (cmdReady && (rdValid || wrReady)) busyCmd = 1'b1;
      if (throttle) begin
        rdReady = tog;
        tog = ~tog;
      end
      if (rdValid && rdReady) begin
        if (rdData !== mdl[base + beats]) bad++;
        beats++;
      end
      if (wrReady) begin
        wrData  = pat(seed, beats);
        wrValid = 1'b1;
        beats++;
      end else begin
        wrValid = 1'b0;
      end
      @(negedge clk);
    end
    wrValid = 1'b0;
    rdReady = 1'b1;
  endtask

  task automatic applyModel(input logic [1:0] op, input int blk, input int pg,
                            input logic [7:0] seed, input logic [1:0] st);
    if (op == 2'd1 && st == 2'd0)
      for (int w = 0; w < NW; w++) mdl[(blk * NP + pg) * NW + w] = pat(seed, w);
    if (op == 2'd2 && st == 2'd0)
      for (int k = 0; k < NP * NW; k++) mdl[blk * NP * NW + k] = 16'hFFFF;
  endtask

  task automatic doStep(input logic [1:0] op, input int blk, input int pg,
                        input logic [7:0] seed, input logic [1:0] exp, input bit throttle);
    logic [1:0] st;
    int beats, bad;
    bit busy;
    string req;
    runCmd(op, blk, pg, seed, throttle, st, beats, bad, busy);
    case (op)
      2'd0: req = "R2 read status";
      2'd1: req = (exp == 2'd0) ? "R3 program status" :
                  (exp == 2'd1) ? "R4 order refusal" : "R5 full refusal";
      2'd2: req = "R6 erase status";
      default: req = "R7 invalid opcode";
    endcase
    check(st == exp, req, st, exp);
    if (op == 2'd0) begin
      check(beats == NW, "R2 read word count", beats, NW);
      check(bad == 0, "R2 read data (R1 R4 R6 R9 contents)", bad, 0);
    end
    if (op == 2'd1)
      check(beats == ((exp == 2'd0) ? NW : 0), "R3 R4 R5 program words taken",
            beats, (exp == 2'd0) ? NW : 0);
    check(!busy, "R8 cmdReady during transfer", busy, 0);
    applyModel(op, blk, pg, seed, st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB * NP * NW; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(cmdReady == 1'b1, "R1 cmdReady", cmdReady, 1);
    check(done == 1'b0, "R1 done", done, 0);
    check(rdValid == 1'b0 && wrReady == 1'b0, "R1 streams idle",
          {rdValid, wrReady}, 0);

    for (int v = 0; v < 16; v++)
      doStep(VEC[v].op, int'(VEC[v].blk), int'(VEC[v].pg), VEC[v].seed, VEC[v].exp, 1'b0);

    // R5: fill block 2, then programs are refused as full
    for (int p = 0; p < NP; p++) doStep(2'd1, 2, p, 8'(8'h60 + p), 2'd0, 1'b0);
    doStep(2'd1, 2, 3, 8'h77, 2'd2, 1'b0);
    doStep(2'd1, 2, 0, 8'h78, 2'd2, 1'b0);
    // R2: read with back-pressure on rdReady
    doStep(2'd0, 2, 7, 8'h00, 2'd0, 1'b1);
    // R9: block 3 pointer untouched by other blocks
    doStep(2'd1, 3, 1, 8'h90, 2'd1, 1'b0);
    doStep(2'd1, 3, 0, 8'h91, 2'd0, 1'b0);
    doStep(2'd0, 3, 0, 8'h00, 2'd0, 1'b0);
    // R6: erasing full block 2 reopens page 0
    doStep(2'd2, 2, 0, 8'h00, 2'd0, 1'b0);
    doStep(2'd1, 2, 0, 8'hAB, 2'd0, 1'b0);
    doStep(2'd0, 2, 0, 8'h00, 2'd0, 1'b0);
    doStep(2'd0, 2, 5, 8'h00, 2'd0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule